// File: doc/BRIEF.md
# Bus-Mapped Parallel Port Controller

This block is a parallel I/O peripheral that a processor reaches over a byte-wide bus. The bus has an active-low chip select, a read/write line, a 5-bit register select and an active-low transfer acknowledge. Behind the bus are three 8-bit ports, A, B and C. Each pin has its own direction bit. A pin whose bit is 1 drives the value held in its output latch. A pin whose bit is 0 is sampled as an input through a two-flop synchronizer. The bus signals are sampled on the block clock.

A general control register selects the port mode, and ports A and B each have a control register that selects a submode. Only the simplest configuration drives pins: mode code 0x00 in the general control register, plus the bit-I/O submode for ports A and B. Any other mode or submode code is stored and can be read back, but the block drives no pin from A or B while it is in effect. Port C has no control register and follows only the general mode. Software brings the block up by writing the mode, the submodes, the direction bits and the data latches. After reset no pin is driven.

Top module: `par_port_ctrl`

## Requirements
- R1: After reset every register reads 0x00 and every output enable (`pa_oe_o`, `pb_oe_o`, `pc_oe_o`) is 0.
- R2: `dtack_no` goes low one clock after `cs_ni` is sampled low and stays low until `cs_ni` goes high. It is high whenever `cs_ni` is high. `data_o` is 0x00 while no acknowledge is given.
- R3: Register select codes are 0 general control, 2/3/4 direction A/B/C, 6/7 control A/B, 8/9/12 data A/B/C. A write stores the full byte, and a read returns it.
- R4: A read of any other select code returns 0x00 and is still acknowledged. A write to such a code changes no register and no pin.
- R5: Writing a data register updates only its latch. `p*_o` carries the latch value, and a read returns the latch bit where the direction bit is 1.
- R6: Where the direction bit is 0, a data register read returns the pin input after a two-flop synchronizer, so a pin change can be read two clocks later.
- R7: A port A or B pin is driven (`oe` = 1) only when its direction bit is 1, control bit 7 is 1 (bit-I/O submode 1X), and general control bits [7:6] are 00.
- R8: A port C pin is driven when its direction bit is 1 and general control bits [7:6] are 00.
- R9: The general control values 0x40, 0x80 and 0xC0 are stored and read back, and they disable drive on all three ports. Writing 0x00 again restores drive.
- R10: Control submodes 00 (0x00) and 01 (0x40) on port A or B are stored and read back, and they drive no pin of that port.
- R11: Output enables change only on the clock edge that performs a bus write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Chip select, active low |
| rw_i | input | 1 | 1 = read, 0 = write |
| rs_i | input | 5 | Register select |
| data_i | input | 8 | Write data |
| data_o | output | 8 | Read data, valid while acknowledged |
| dtack_no | output | 1 | Transfer acknowledge, active low |
| pa_i | input | 8 | Port A pin inputs |
| pa_o | output | 8 | Port A output latch |
| pa_oe_o | output | 8 | Port A per-pin drive enable |
| pb_i | input | 8 | Port B pin inputs |
| pb_o | output | 8 | Port B output latch |
| pb_oe_o | output | 8 | Port B per-pin drive enable |
| pc_i | input | 8 | Port C pin inputs |
| pc_o | output | 8 | Port C output latch |
| pc_oe_o | output | 8 | Port C per-pin drive enable |

## Verification
Port A is set up with a split direction mask (0x0F) and different latch and pin values. A read that is half latch and half pin then shows whether the per-bit readback multiplexer picks the right source for each bit. Port B is set up with all pins as outputs and port C with an interior mask. Each control submode and each general mode code is written in turn. The enables are checked after each write, which separates the gating by mode from the gating by submode and shows that port C ignores the submode. Reads and writes to unused select codes are followed by readback of the live registers, which shows whether a stray decode has changed any state.

// File: rtl/ppc_pkg.sv
package ppc_pkg;
  localparam int unsigned DW   = 8;
  localparam int unsigned RS_W = 5;

  localparam logic [RS_W-1:0] SEL_GCR    = 5'd0;
  localparam logic [RS_W-1:0] SEL_DIR_A  = 5'd2;
  localparam logic [RS_W-1:0] SEL_DIR_B  = 5'd3;
  localparam logic [RS_W-1:0] SEL_DIR_C  = 5'd4;
  localparam logic [RS_W-1:0] SEL_CTL_A  = 5'd6;
  localparam logic [RS_W-1:0] SEL_CTL_B  = 5'd7;
  localparam logic [RS_W-1:0] SEL_DAT_A  = 5'd8;
  localparam logic [RS_W-1:0] SEL_DAT_B  = 5'd9;
  localparam logic [RS_W-1:0] SEL_DAT_C  = 5'd12;

  // general mode field [7:6] == 00 selects plain 8-bit unidirectional
  function automatic logic gcr_plain(input logic [DW-1:0] g);
    return g[DW-1 -: 2] == 2'b00;
  endfunction

  // control submode 1X selects bit I/O
  function automatic logic ctl_bitio(input logic [DW-1:0] c);
    return c[DW-1];
  endfunction

  function automatic logic sel_known(input logic [RS_W-1:0] s);
    return s inside {SEL_GCR, SEL_DIR_A, SEL_DIR_B, SEL_DIR_C,
                     SEL_CTL_A, SEL_CTL_B, SEL_DAT_A, SEL_DAT_B, SEL_DAT_C};
  endfunction
endpackage

// File: rtl/ppc_sync2.sv
module ppc_sync2 #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/ppc_bus_ack.sv
module ppc_bus_ack (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  output logic access_o,
  output logic ack_o,
  output logic dtack_no
);
  logic ack_q;

  // one access per select assertion, on the edge that raises ack
  assign access_o = !cs_ni && !ack_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ack_q <= 1'b0;
    else if (cs_ni) ack_q <= 1'b0;
    else            ack_q <= 1'b1;
  end

  assign ack_o    = ack_q && !cs_ni;
  assign dtack_no = !ack_o;
endmodule

// File: rtl/ppc_port.sv
module ppc_port #(
  parameter int unsigned W        = 8,
  parameter bit          HAS_CTRL = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic         sel_dir_i,
  input  logic         sel_ctl_i,
  input  logic         sel_dat_i,
  input  logic [W-1:0] wdata_i,
  input  logic         mode_ok_i,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] pin_o,
  output logic [W-1:0] pin_oe_o,
  output logic [W-1:0] dir_o,
  output logic [W-1:0] ctl_o,
  output logic [W-1:0] rd_o
);
  logic [W-1:0] dir_q, dat_q, pin_s;
  logic         drive_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q <= '0;
      dat_q <= '0;
    end else if (wr_i) begin
      if (sel_dir_i) dir_q <= wdata_i;
      if (sel_dat_i) dat_q <= wdata_i;
    end
  end

  generate
    if (HAS_CTRL) begin : g_ctl
      logic [W-1:0] ctl_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                 ctl_q <= '0;
        else if (wr_i && sel_ctl_i)  ctl_q <= wdata_i;
      end
      assign ctl_o    = ctl_q;
      assign drive_ok = mode_ok_i && ctl_q[W-1];
    end else begin : g_no_ctl
      logic unused_sel;
      assign unused_sel = sel_ctl_i;
      assign ctl_o      = '0;
      assign drive_ok   = mode_ok_i;
    end
  endgenerate

  ppc_sync2 #(.W(W)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (pin_s)
  );

  assign pin_o    = dat_q;
  assign pin_oe_o = dir_q & {W{drive_ok}};
  assign dir_o    = dir_q;
  assign rd_o     = (dat_q & dir_q) | (pin_s & ~dir_q);
endmodule

// File: rtl/par_port_ctrl.sv
module par_port_ctrl
  import ppc_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cs_ni,
  input  logic            rw_i,
  input  logic [RS_W-1:0] rs_i,
  input  logic [DW-1:0]   data_i,
  output logic [DW-1:0]   data_o,
  output logic            dtack_no,
  input  logic [DW-1:0]   pa_i,
  output logic [DW-1:0]   pa_o,
  output logic [DW-1:0]   pa_oe_o,
  input  logic [DW-1:0]   pb_i,
  output logic [DW-1:0]   pb_o,
  output logic [DW-1:0]   pb_oe_o,
  input  logic [DW-1:0]   pc_i,
  output logic [DW-1:0]   pc_o,
  output logic [DW-1:0]   pc_oe_o
);
  logic          access, ack, wr;
  logic [DW-1:0] gcr_q;
  logic          plain;
  logic [DW-1:0] dir_a, dir_b, dir_c, ctl_a, ctl_b, ctl_c_unused;
  logic [DW-1:0] rd_a, rd_b, rd_c;
  logic [DW-1:0] rd_mux;

  ppc_bus_ack i_ack (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cs_ni   (cs_ni),
    .access_o(access),
    .ack_o   (ack),
    .dtack_no(dtack_no)
  );

  assign wr = access && !rw_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     gcr_q <= '0;
    else if (wr && rs_i == SEL_GCR)  gcr_q <= data_i;
  end

  assign plain = gcr_plain(gcr_q);

  ppc_port #(.W(DW), .HAS_CTRL(1'b1)) i_port_a (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (wr),
    .sel_dir_i(rs_i == SEL_DIR_A),
    .sel_ctl_i(rs_i == SEL_CTL_A),
    .sel_dat_i(rs_i == SEL_DAT_A),
    .wdata_i  (data_i),
    .mode_ok_i(plain),
    .pin_i    (pa_i),
    .pin_o    (pa_o),
    .pin_oe_o (pa_oe_o),
    .dir_o    (dir_a),
    .ctl_o    (ctl_a),
    .rd_o     (rd_a)
  );

  ppc_port #(.W(DW), .HAS_CTRL(1'b1)) i_port_b (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (wr),
    .sel_dir_i(rs_i == SEL_DIR_B),
    .sel_ctl_i(rs_i == SEL_CTL_B),
    .sel_dat_i(rs_i == SEL_DAT_B),
    .wdata_i  (data_i),
    .mode_ok_i(plain),
    .pin_i    (pb_i),
    .pin_o    (pb_o),
    .pin_oe_o (pb_oe_o),
    .dir_o    (dir_b),
    .ctl_o    (ctl_b),
    .rd_o     (rd_b)
  );

  ppc_port #(.W(DW), .HAS_CTRL(1'b0)) i_port_c (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (wr),
    .sel_dir_i(rs_i == SEL_DIR_C),
    .sel_ctl_i(1'b0),
    .sel_dat_i(rs_i == SEL_DAT_C),
    .wdata_i  (data_i),
    .mode_ok_i(plain),
    .pin_i    (pc_i),
    .pin_o    (pc_o),
    .pin_oe_o (pc_oe_o),
    .dir_o    (dir_c),
    .ctl_o    (ctl_c_unused),
    .rd_o     (rd_c)
  );

  always_comb begin
    unique case (rs_i)
      SEL_GCR:   rd_mux = gcr_q;
      SEL_DIR_A: rd_mux = dir_a;
      SEL_DIR_B: rd_mux = dir_b;
      SEL_DIR_C: rd_mux = dir_c;
      SEL_CTL_A: rd_mux = ctl_a;
      SEL_CTL_B: rd_mux = ctl_b;
      SEL_DAT_A: rd_mux = rd_a;
      SEL_DAT_B: rd_mux = rd_b;
      SEL_DAT_C: rd_mux = rd_c;
      default:   rd_mux = '0;
    endcase
  end

  assign data_o = (ack && rw_i) ? rd_mux : '0;
endmodule

// File: rtl/ppc_chk.sv
module ppc_chk
  import ppc_pkg::*;
(
  input logic            clk_i,
  input logic            rst_ni,
  input logic            cs_ni,
  input logic            rw_i,
  input logic [RS_W-1:0] rs_i,
  input logic [DW-1:0]   data_i,
  input logic [DW-1:0]   data_o,
  input logic            dtack_no,
  input logic [DW-1:0]   pa_oe_o,
  input logic [DW-1:0]   pb_oe_o,
  input logic [DW-1:0]   pc_oe_o,
  input logic [DW-1:0]   gcr_q
);
  // R2
  idle_no_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |-> dtack_no);

  // R2
  ack_follows_select_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_ni) |=> (cs_ni || !dtack_no));

  // R2
  idle_bus_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dtack_no |-> data_o == '0);

  // R4
  unknown_read_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dtack_no && rw_i && !sel_known(rs_i)) |-> data_o == '0);

  // R11
  drive_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!cs_ni && !rw_i) |=> $stable({pa_oe_o, pb_oe_o, pc_oe_o}));

  // R8
  pc_dir_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_ni && !rw_i && dtack_no && rs_i == SEL_DIR_C && gcr_plain(gcr_q))
    |=> pc_oe_o == $past(data_i));
endmodule

bind par_port_ctrl ppc_chk i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .cs_ni   (cs_ni),
  .rw_i    (rw_i),
  .rs_i    (rs_i),
  .data_i  (data_i),
  .data_o  (data_o),
  .dtack_no(dtack_no),
  .pa_oe_o (pa_oe_o),
  .pb_oe_o (pb_oe_o),
  .pc_oe_o (pc_oe_o),
  .gcr_q   (gcr_q)
);

// File: tb/test_par_port_ctrl.sv
module test_par_port_ctrl;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cs_ni = 1'b1;
  logic       rw_i = 1'b1;
  logic [4:0] rs_i = '0;
  logic [7:0] data_i = '0;
  logic [7:0] data_o;
  logic       dtack_no;
  logic [7:0] pa_i = '0, pb_i = '0, pc_i = '0;
  logic [7:0] pa_o, pa_oe_o, pb_o, pb_oe_o, pc_o, pc_oe_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0] exp_q[$];
  string      tag_q[$];
  bit         seen = 1'b0;

  always #2.5 clk_i = ~clk_i;

  par_port_ctrl i_par_port_ctrl (.*);

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  // monitor: compare read data once per acknowledged read
  always @(negedge clk_i) begin
    if (!dtack_no && rw_i && !cs_ni && !seen && exp_q.size() > 0) begin
      chk(data_o, exp_q.pop_front(), tag_q.pop_front());
      seen = 1'b1;
    end
    if (dtack_no) seen = 1'b0;
  end

  task automatic wr(input logic [4:0] rs, input logic [7:0] d);
    @(negedge clk_i);
    cs_ni = 1'b0; rw_i = 1'b0; rs_i = rs; data_i = d;
    @(negedge clk_i);
    @(negedge clk_i);
    cs_ni = 1'b1; rw_i = 1'b1;
  endtask

  task automatic rd(input logic [4:0] rs, input logic [7:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk_i);
    cs_ni = 1'b0; rw_i = 1'b1; rs_i = rs;
    @(negedge clk_i);
    @(negedge clk_i);
    cs_ni = 1'b1;
  endtask

  task automatic chk_oe(input logic [7:0] a, input logic [7:0] b, input logic [7:0] c,
                        input string tag);
    chk(pa_oe_o, a, {tag, " pa_oe"});
    chk(pb_oe_o, b, {tag, " pb_oe"});
    chk(pc_oe_o, c, {tag, " pc_oe"});
  endtask

  task automatic chk_all_zero(input string tag);
    foreach (exp_q[i]) ;
    rd(5'd0, 8'h00, tag);  rd(5'd2, 8'h00, tag);  rd(5'd3, 8'h00, tag);
    rd(5'd4, 8'h00, tag);  rd(5'd6, 8'h00, tag);  rd(5'd7, 8'h00, tag);
    rd(5'd8, 8'h00, tag);  rd(5'd9, 8'h00, tag);  rd(5'd12, 8'h00, tag);
    chk_oe(8'h00, 8'h00, 8'h00, tag);
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 reset state
    chk_all_zero("R1 reset");

    // R2 acknowledge timing
    @(negedge clk_i);
    chk({7'd0, dtack_no}, 8'd1, "R2 idle dtack");
    cs_ni = 1'b0; rw_i = 1'b1; rs_i = 5'd1;
    #1 chk({7'd0, dtack_no}, 8'd1, "R2 no ack before edge");
    @(negedge clk_i);
    chk({7'd0, dtack_no}, 8'd0, "R2 ack one clock later");
    repeat (3) @(negedge clk_i);
    chk({7'd0, dtack_no}, 8'd0, "R2 ack held");
    cs_ni = 1'b1;
    #1 chk({7'd0, dtack_no}, 8'd1, "R2 release on deselect");
    chk(data_o, 8'h00, "R2 idle data");

    // port A: split direction, bit I/O
    wr(5'd0, 8'h00);
    wr(5'd2, 8'h0F);
    chk(pa_oe_o, 8'h00, "R7 no drive before submode");
    wr(5'd6, 8'h80);
    wr(5'd8, 8'hA5);
    chk(pa_oe_o, 8'h0F, "R7 bitio drive");
    chk(pa_o, 8'hA5, "R5 latch on pins");
    pa_i = 8'h3C;
    repeat (3) @(negedge clk_i);
    rd(5'd8, 8'h35, "R5 R6 mixed readback");
    rd(5'd2, 8'h0F, "R3 dir A");
    rd(5'd6, 8'h80, "R3 ctl A");
    @(negedge clk_i) pa_i = 8'hF0;
    repeat (2) @(negedge clk_i);
    rd(5'd8, 8'hF5, "R6 synced input change");

    // R10 submodes 01 and 00 drive nothing
    wr(5'd6, 8'h40);
    chk(pa_oe_o, 8'h00, "R10 submode 01");
    rd(5'd6, 8'h40, "R10 ctl readback 01");
    wr(5'd6, 8'h00);
    chk(pa_oe_o, 8'h00, "R10 submode 00");
    wr(5'd6, 8'hC0);
    chk(pa_oe_o, 8'h0F, "R7 submode 11 is bit I/O");

    // port B all outputs
    wr(5'd3, 8'hFF);
    wr(5'd7, 8'h80);
    wr(5'd9, 8'h18);
    chk(pb_oe_o, 8'hFF, "R7 port B drive");
    chk(pb_o, 8'h18, "R5 port B latch");
    pb_i = 8'hE7;
    repeat (3) @(negedge clk_i);
    rd(5'd9, 8'h18, "R5 port B readback ignores pins");

    // port C ignores submodes, follows general mode
    wr(5'd4, 8'h3C);
    wr(5'd12, 8'h81);
    chk(pc_oe_o, 8'h3C, "R8 port C drive");
    chk(pc_o, 8'h81, "R5 port C latch");
    pc_i = 8'h42;
    repeat (3) @(negedge clk_i);
    rd(5'd12, 8'h42, "R8 R6 port C readback");

    // R9 other general modes
    wr(5'd0, 8'h40);
    chk_oe(8'h00, 8'h00, 8'h00, "R9 mode 0x40");
    rd(5'd0, 8'h40, "R9 gcr 0x40");
    wr(5'd0, 8'h80);
    chk_oe(8'h00, 8'h00, 8'h00, "R9 mode 0x80");
    rd(5'd0, 8'h80, "R9 gcr 0x80");
    wr(5'd0, 8'hC0);
    chk_oe(8'h00, 8'h00, 8'h00, "R9 mode 0xC0");
    rd(5'd0, 8'hC0, "R9 gcr 0xC0");
    wr(5'd0, 8'h00);
    chk_oe(8'h0F, 8'hFF, 8'h3C, "R9 mode 0 restored");

    // R4 unknown selects
    rd(5'd1, 8'h00, "R4 read sel 1");
    rd(5'd5, 8'h00, "R4 read sel 5");
    rd(5'd10, 8'h00, "R4 read sel 10");
    rd(5'd13, 8'h00, "R4 read sel 13");
    rd(5'd31, 8'h00, "R4 read sel 31");
    wr(5'd5, 8'hFF);
    wr(5'd11, 8'h00);
    wr(5'd1, 8'h55);
    chk_oe(8'h0F, 8'hFF, 8'h3C, "R4 pins after stray writes");
    rd(5'd0, 8'h00, "R4 gcr kept");
    rd(5'd2, 8'h0F, "R4 dir A kept");
    rd(5'd7, 8'h80, "R4 ctl B kept");
    rd(5'd4, 8'h3C, "R4 dir C kept");
    rd(5'd12, 8'h42, "R4 data C kept");

    // R11 reads leave drive untouched
    rd(5'd9, 8'h18, "R11 read B");
    chk_oe(8'h0F, 8'hFF, 8'h3C, "R11 after reads");

    // R1 reset mid-run
    @(negedge clk_i) rst_ni = 1'b0;
    #1 chk_oe(8'h00, 8'h00, 8'h00, "R1 async reset");
    @(negedge clk_i) rst_ni = 1'b1;
    pa_i = '0; pb_i = '0; pc_i = '0;
    repeat (3) @(negedge clk_i);
    chk_all_zero("R1 after second reset");

    repeat (2) @(negedge clk_i);
    chk(8'(exp_q.size()), 8'd0, "scoreboard drained");
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule